// File: doc/BRIEF.md
# Dual Four-Mode Timer/Counter

This block contains two independent timer/counters. Each one holds a low count byte and a high count byte. The counters are loaded and controlled through a small register write port. A shared control byte gives each timer three things: a 2-bit mode, a bit that chooses what it counts, and a gate bit. A second register holds the two run bits and the two sticky overflow flags. The counts and the flags are brought out as plain outputs.

Each timer counts one of two sources, chosen by its count-select bit:
- every clock cycle, or
- falling edges on its own external count pin.

The timer can be gated by an external level pin, which allows the width of a pulse on that pin to be measured.

The four modes are:
- a 13-bit counter: a 5-bit prescaler in the low byte feeding the high byte;
- a 16-bit counter;
- an 8-bit counter that reloads from the high byte;
- a split mode. In split mode, timer 0's low byte counts alone and timer 0's high byte becomes an extra 8-bit timer. That extra timer is enabled by timer 1's run bit and drives timer 1's overflow flag.

Top module: `dual_mode_timer`

## Requirements
- R1: Mode code 0 (mode bits [1:0] of the timer's control nibble): only the lowest 5 bits of the low byte count, and the upper 3 bits keep their value. The high byte increments when those 5 bits wrap from all ones. The timer's flag is set when both the 5 bits and the high byte are all ones and a count occurs.
- R2: Mode code 1: high and low bytes form one 16-bit counter. The flag is set when a count occurs at 16'hFFFF, which wraps the counter to 0.
- R3: Mode code 2: the low byte counts. A count at 8'hFF loads the low byte with the high byte instead of wrapping, and sets the flag. The high byte is never changed by counting.
- R4: Timer 0 with mode code 3:
  - Timer 0's low byte counts under timer 0's own controls and sets flag 0.
  - Timer 0's high byte increments every clock cycle while run bit 1 is set, and sets flag 1 when it wraps from 8'hFF.
  - Timer 1 with mode code 3 holds its count.
- R5: Count-select bit (nibble bit 2):
  - 0: one count per clock cycle while enabled.
  - 1: one count per falling edge of the timer's count pin, after a two-flop synchronizer. There is at most one count per clock.
- R6: A timer counts only while its run bit is 1 and either its gate bit (nibble bit 3) is 0 or its synchronized gate pin is high.
- R7: Flag handling:
  - Overflow flags (bit 4 for timer 0 and bit 5 for timer 1 of register 5) stay set until a write to register 5 carries 0 in that bit position.
  - Writing 1 in that position leaves the flag unchanged.
  - An overflow in the same cycle as a clearing write leaves the flag set.
- R8: Register addresses:
  - 0 and 1: timer 0 low and high byte.
  - 2 and 3: timer 1 low and high byte.
  - 4: control byte. Timer 0 uses bits [3:0] and timer 1 uses bits [7:4].
  - 5: run bits [1:0] and flags.
  - A write to a count byte takes effect on the next clock edge, overriding a count in that same cycle.
- R9: After reset, all counts, control bits, run bits and flags are 0.
- R10: While timer 0 uses mode code 3, timer 1 still counts under its own mode and controls, but its own overflow does not set flag 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| cnt_pin | input | 2 | External count inputs, bit i for timer i |
| gate_pin | input | 2 | External gate level inputs, bit i for timer i |
| t0_count | output | 16 | Timer 0 {high, low} bytes |
| t1_count | output | 16 | Timer 1 {high, low} bytes |
| ovf_flag | output | 2 | Sticky overflow flags, bit i for timer i |

## Verification
The bench builds the block with its default parameters: 8-bit count bytes, a 5-bit prescaler and a two-stage synchronizer. With these values, every wrap point can be reached in a few cycles by preloading counts just below all ones. That covers the prescaler wrap into the high byte, the 16-bit rollover, the reload at 8'hFF and the split-mode high-byte wrap. The short synchronizer keeps the delay between a pin edge and its count small enough to check external counting and gating with a few idle cycles of margin.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int NUM_TMR = 2;

   typedef enum logic [1:0] {
      MODE_PRESCALE = 2'd0,
      MODE_CASCADE  = 2'd1,
      MODE_RELOAD   = 2'd2,
      MODE_SPLIT    = 2'd3
   } tmr_mode_e;

   typedef enum logic [2:0] {
      ADR_T0_LO  = 3'd0,
      ADR_T0_HI  = 3'd1,
      ADR_T1_LO  = 3'd2,
      ADR_T1_HI  = 3'd3,
      ADR_CTRL   = 3'd4,
      ADR_RUNFLG = 3'd5
   } tmr_addr_e;
endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic level,
   output logic fall
);
   logic [STAGES-1:0] sh_q;
   logic              prev_q;

   generate
      if (STAGES < 2) begin : g_bad
         $fatal(1, "tmr_pin_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         prev_q <= 1'b0;
      end else begin
         sh_q   <= {sh_q[STAGES-2:0], pin};
         prev_q <= sh_q[STAGES-1];
      end
   end

   assign level = sh_q[STAGES-1];
   assign fall  = prev_q & ~sh_q[STAGES-1];

   // R5: a detected edge is a single-cycle pulse
   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall);
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
   import tmr_pkg::*;
#(
   parameter int W = 8,
   parameter int P = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  tmr_mode_e    mode,
   input  logic         inc,
   input  logic         hi_inc,
   input  logic         wr_lo,
   input  logic         wr_hi,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] lo,
   output logic [W-1:0] hi,
   output logic         lo_ovf,
   output logic         hi_ovf
);
   localparam logic [P-1:0]   P_ONE = 1;
   localparam logic [W-1:0]   W_ONE = 1;
   localparam logic [2*W-1:0] D_ONE = 1;

   logic [W-1:0] lo_q, hi_q, lo_n, hi_n;

   generate
      if (P < 1 || P >= W) begin : g_bad
         $fatal(1, "tmr_count_core: prescaler width must be 1..W-1");
      end
   endgenerate

   always_comb begin
      lo_n   = lo_q;
      hi_n   = hi_q;
      lo_ovf = 1'b0;
      hi_ovf = 1'b0;
      unique case (mode)
         MODE_PRESCALE: if (inc) begin
            lo_n[P-1:0] = lo_q[P-1:0] + P_ONE;
            if (&lo_q[P-1:0]) begin
               hi_n   = hi_q + W_ONE;
               lo_ovf = &hi_q;
            end
         end
         MODE_CASCADE: if (inc) begin
            {hi_n, lo_n} = {hi_q, lo_q} + D_ONE;
            lo_ovf       = &{hi_q, lo_q};
         end
         MODE_RELOAD: if (inc) begin
            if (&lo_q) begin
               lo_n   = hi_q;
               lo_ovf = 1'b1;
            end else begin
               lo_n = lo_q + W_ONE;
            end
         end
         MODE_SPLIT: begin
            if (inc) begin
               lo_n   = lo_q + W_ONE;
               lo_ovf = &lo_q;
            end
            if (hi_inc) begin
               hi_n   = hi_q + W_ONE;
               hi_ovf = &hi_q;
            end
         end
      endcase
      if (wr_lo) lo_n = wr_data;
      if (wr_hi) hi_n = wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else begin
         lo_q <= lo_n;
         hi_q <= hi_n;
      end
   end

   assign lo = lo_q;
   assign hi = hi_q;

   // R1: no carry into the high byte before the prescaler bits wrap
   a_r1_prescale_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_PRESCALE && inc && !(&lo_q[P-1:0]) && !wr_hi) |=> $stable(hi_q));
   // R2: low byte rollover carries into the high byte
   a_r2_cascade_carry: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_CASCADE && inc && (&lo_q) && !wr_lo && !wr_hi)
      |=> (lo_q == '0 && hi_q == $past(hi_q) + W_ONE));
   // R3: overflow reloads from the high byte
   a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_RELOAD && inc && (&lo_q) && !wr_lo) |=> lo_q == $past(hi_q));
endmodule

// File: rtl/dual_mode_timer.sv
module dual_mode_timer
   import tmr_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int PRE_W       = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [2:0]         wr_addr,
   input  logic [CNT_W-1:0]   wr_data,
   input  logic [1:0]         cnt_pin,
   input  logic [1:0]         gate_pin,
   output logic [2*CNT_W-1:0] t0_count,
   output logic [2*CNT_W-1:0] t1_count,
   output logic [1:0]         ovf_flag
);
   localparam int NIB = 4;

   logic [CNT_W-1:0] ctl_q;
   logic [1:0]       run_q, flag_q, flag_n;
   tmr_mode_e        mode   [NUM_TMR];
   logic [CNT_W-1:0] lo_w   [NUM_TMR];
   logic [CNT_W-1:0] hi_w   [NUM_TMR];
   logic [1:0]       en, tick, inc, hinc, lo_ovf, hi_ovf, set_flag;
   logic [1:0]       gsync, cfall, gsync_unused_fall, cnt_level_unused;
   logic             split;
   logic             wr_ctl, wr_rf;

   generate
      if (CNT_W < 8) begin : g_bad
         $fatal(1, "dual_mode_timer: CNT_W must hold control and flag fields");
      end
   endgenerate

   assign wr_ctl = wr_en && (wr_addr == ADR_CTRL);
   assign wr_rf  = wr_en && (wr_addr == ADR_RUNFLG);
   assign split  = (mode[0] == MODE_SPLIT);

   generate
      for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
         logic cksel, gate;
         assign mode[i] = tmr_mode_e'(ctl_q[NIB*i +: 2]);
         assign cksel   = ctl_q[NIB*i + 2];
         assign gate    = ctl_q[NIB*i + 3];

         tmr_pin_sync #(.STAGES(SYNC_STAGES)) i_cnt_sync (
            .clk(clk), .rst_n(rst_n), .pin(cnt_pin[i]),
            .level(cnt_level_unused[i]), .fall(cfall[i]));
         tmr_pin_sync #(.STAGES(SYNC_STAGES)) i_gate_sync (
            .clk(clk), .rst_n(rst_n), .pin(gate_pin[i]),
            .level(gsync[i]), .fall(gsync_unused_fall[i]));

         assign en[i]   = run_q[i] & (~gate | gsync[i]);
         assign tick[i] = cksel ? cfall[i] : 1'b1;

         tmr_count_core #(.W(CNT_W), .P(PRE_W)) i_core (
            .clk(clk), .rst_n(rst_n), .mode(mode[i]),
            .inc(inc[i]), .hi_inc(hinc[i]),
            .wr_lo(wr_en && (wr_addr == 3'(2*i))),
            .wr_hi(wr_en && (wr_addr == 3'(2*i+1))),
            .wr_data(wr_data), .lo(lo_w[i]), .hi(hi_w[i]),
            .lo_ovf(lo_ovf[i]), .hi_ovf(hi_ovf[i]));
      end
   endgenerate

   assign inc[0]  = en[0] & tick[0];
   assign inc[1]  = (mode[1] == MODE_SPLIT) ? 1'b0 : (en[1] & tick[1]);
   assign hinc[0] = split & run_q[1];
   assign hinc[1] = 1'b0;

   assign set_flag[0] = lo_ovf[0];
   assign set_flag[1] = split ? hi_ovf[0] : lo_ovf[1];

   always_comb begin
      flag_n = flag_q;
      if (wr_rf) flag_n = flag_q & wr_data[5:4];
      flag_n = flag_n | set_flag;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q  <= '0;
         run_q  <= '0;
         flag_q <= '0;
      end else begin
         if (wr_ctl) ctl_q <= wr_data;
         if (wr_rf)  run_q <= wr_data[1:0];
         flag_q <= flag_n;
      end
   end

   assign t0_count = {hi_w[0], lo_w[0]};
   assign t1_count = {hi_w[1], lo_w[1]};
   assign ovf_flag = flag_q;

   // R7: a flag survives any cycle without a clearing write
   a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[0] && !(wr_rf && !wr_data[4])) |=> flag_q[0]);
   // R6: a stopped timer 0 keeps its low byte
   a_r6_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q[0] && !(wr_en && wr_addr == ADR_T0_LO)) |=> $stable(t0_count[CNT_W-1:0]));
   // R4: timer 1 in split code holds its count
   a_r4_t1_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[1] == MODE_SPLIT && !(wr_en && (wr_addr == ADR_T1_LO || wr_addr == ADR_T1_HI)))
      |=> $stable(t1_count));
   // R10: in split mode timer 1's own rollover never raises flag 1
   a_r10_no_t1_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (split && !hi_ovf[0] && !flag_q[1]) |=> !flag_q[1]);
endmodule

// File: tb/test_dual_mode_timer.sv
`timescale 1ns/1ps
module test_dual_mode_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [1:0]  cnt_pin = '0;
   logic [1:0]  gate_pin = '0;
   logic [15:0] t0_count, t1_count;
   logic [1:0]  ovf_flag;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   dual_mode_timer i_dual_mode_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
      .t0_count(t0_count), .t1_count(t1_count), .ovf_flag(ovf_flag));

   // fields: gate pin, ctrl, lo, hi, cycles, expected lo, expected hi, expected flag0
   localparam int NV = 9;
   localparam logic [49:0] VEC [NV] = '{
      {1'b0, 8'h01, 8'hFE, 8'h12, 8'd3, 8'h01, 8'h13, 1'b0},
      {1'b0, 8'h01, 8'hFE, 8'hFF, 8'd3, 8'h01, 8'h00, 1'b1},
      {1'b0, 8'h00, 8'hFE, 8'h05, 8'd3, 8'hE1, 8'h06, 1'b0},
      {1'b0, 8'h00, 8'h1F, 8'hFF, 8'd1, 8'h00, 8'h00, 1'b1},
      {1'b0, 8'h02, 8'hFD, 8'h80, 8'd5, 8'h82, 8'h80, 1'b1},
      {1'b0, 8'h02, 8'h10, 8'hF0, 8'd4, 8'h14, 8'hF0, 1'b0},
      {1'b0, 8'h03, 8'hFF, 8'h00, 8'd2, 8'h01, 8'h00, 1'b1},
      {1'b0, 8'h09, 8'h40, 8'h00, 8'd5, 8'h40, 8'h00, 1'b0},
      {1'b1, 8'h09, 8'h40, 8'h00, 8'd5, 8'h45, 8'h00, 1'b0}
   };

   function automatic string vtag(int k);
      case (k)
         0, 1:    return "R2";
         2, 3:    return "R1";
         4, 5:    return "R3";
         6:       return "R4";
         default: return "R6";
      endcase
   endfunction

   task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // called at a falling edge; the write lands on the next rising edge
   task automatic write_reg(logic [2:0] a, logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // exactly n counting edges, flags kept
   task automatic run_for(int n, logic [1:0] runs);
      write_reg(3'd5, 8'h30 | {6'd0, runs});
      repeat (n - 1) @(negedge clk);
      write_reg(3'd5, 8'h30);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++; n_tests++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk("R9", t0_count, 16'h0000);
      chk("R9", t1_count, 16'h0000);
      chk("R9", {14'd0, ovf_flag}, 16'h0000);

      for (int k = 0; k < NV; k++) begin
         gate_pin[0] = VEC[k][49];
         write_reg(3'd0, VEC[k][40:33]);
         write_reg(3'd1, VEC[k][32:25]);
         write_reg(3'd4, VEC[k][48:41]);
         write_reg(3'd5, 8'h00);
         run_for(int'(VEC[k][24:17]), 2'b01);
         @(negedge clk);
         chk(vtag(k), {8'd0, t0_count[7:0]}, {8'd0, VEC[k][16:9]});
         chk(vtag(k), {8'd0, t0_count[15:8]}, {8'd0, VEC[k][8:1]});
         chk("R7", {15'd0, ovf_flag[0]}, {15'd0, VEC[k][0]});
      end
      gate_pin = '0;

      // R6: run bit clear, no counting
      write_reg(3'd4, 8'h01);
      write_reg(3'd0, 8'h20); write_reg(3'd1, 8'h00);
      repeat (5) @(negedge clk);
      chk("R6", t0_count, 16'h0020);

      // R5: external falling edges
      write_reg(3'd0, 8'h00);
      write_reg(3'd4, 8'h05);
      write_reg(3'd5, 8'h01);
      for (int p = 0; p < 4; p++) begin
         cnt_pin[0] = 1'b1; repeat (3) @(negedge clk);
         cnt_pin[0] = 1'b0; repeat (3) @(negedge clk);
      end
      repeat (6) @(negedge clk);
      chk("R5", t0_count, 16'h0004);
      repeat (10) @(negedge clk);
      chk("R5", t0_count, 16'h0004);
      write_reg(3'd5, 8'h00);

      // R4: split mode, timer 0 high byte on run bit 1
      write_reg(3'd0, 8'h10); write_reg(3'd1, 8'hFE);
      write_reg(3'd2, 8'h00); write_reg(3'd3, 8'h00);
      write_reg(3'd4, 8'h13);
      write_reg(3'd5, 8'h00);
      run_for(3, 2'b10);
      @(negedge clk);
      chk("R4", t0_count, 16'h0110);
      chk("R4", {14'd0, ovf_flag}, 16'h0002);
      chk("R4", t1_count, 16'h0003);

      // R10: timer 1 rollover does not reach flag 1 in split mode
      write_reg(3'd1, 8'h00);
      write_reg(3'd2, 8'hFF); write_reg(3'd3, 8'hFF);
      write_reg(3'd5, 8'h00);
      run_for(2, 2'b10);
      @(negedge clk);
      chk("R10", t1_count, 16'h0001);
      chk("R10", {14'd0, ovf_flag}, 16'h0000);
      chk("R10", t0_count, 16'h0210);

      // R4: timer 1 with code 3 holds
      write_reg(3'd4, 8'h30);
      write_reg(3'd2, 8'h07); write_reg(3'd3, 8'h00);
      run_for(4, 2'b10);
      @(negedge clk);
      chk("R4", t1_count, 16'h0007);
      chk("R4", t0_count, 16'h0210);

      // R7: sticky flag, write-one keeps, write-zero clears
      write_reg(3'd4, 8'h01);
      write_reg(3'd0, 8'hFF); write_reg(3'd1, 8'hFF);
      write_reg(3'd5, 8'h00);
      run_for(1, 2'b01);
      @(negedge clk);
      chk("R7", {15'd0, ovf_flag[0]}, 16'h0001);
      write_reg(3'd5, 8'h30);
      chk("R7", {15'd0, ovf_flag[0]}, 16'h0001);
      write_reg(3'd5, 8'h20);
      chk("R7", {15'd0, ovf_flag[0]}, 16'h0000);

      // R7: overflow beats a clearing write in the same cycle
      write_reg(3'd0, 8'hFE); write_reg(3'd1, 8'hFF);
      write_reg(3'd5, 8'h31);
      @(negedge clk);
      write_reg(3'd5, 8'h20);
      chk("R7", {15'd0, ovf_flag[0]}, 16'h0001);
      chk("R2", t0_count, 16'h0000);

      // R8: a count-byte write overrides a count
      write_reg(3'd5, 8'h00);
      write_reg(3'd0, 8'h00); write_reg(3'd1, 8'h00);
      write_reg(3'd5, 8'h01);
      write_reg(3'd0, 8'h55);
      chk("R8", t0_count, 16'h0055);
      write_reg(3'd5, 8'h00);
      chk("R8", t0_count, 16'h0056);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule